// File: doc/BRIEF.md
# Phase-Sampled Timer/Counter with Shared Prescaler

The block is an 8-bit up-counter that runs either from the core's own instruction cycle or from an external pin. One instruction cycle is four oscillator clocks, named phases Q1 to Q4. A free-running phase counter produces these phases, and reset starts it at Q1. A single 8-bit prescaler serves one of two paths. When it belongs to the timer, it divides the timer's count source. When it belongs to the watchdog, it divides a tick strobe that arrives from the watchdog oscillator. Both paths never use it at the same time. A 3-bit ratio field sets the division, and the prescaler count is never visible or loadable.

The external signal passes through a polarity select first. It then goes either straight to the sampler or through the prescaler, depending on the assignment. The sampler latches it at the end of Q2 and at the end of Q4 of every cycle. Increments therefore always land on the Q4 clock edge, fully synchronous to the core.

Every input is a plain control pin that is sampled on each clock. The write strobe has no handshake and no back-pressure: a write in any cycle is taken at once and always wins over an increment in that same cycle. The overflow pulse and the watchdog tick are single-cycle strobes that the consumer cannot stall.

Top module: `tmr_unit`

## Requirements
- R1: After reset, `tmr_value` is 0x00, and `tmr_ovf` and `wdt_tick` are low. The prescaler count is zero and the phase is Q1.
- R2: With `cfg_src_ext`=0 and `cfg_assign_wdt`=1 (prescaler not used by the timer), the timer adds exactly one per Q4 edge.
- R3: A pulse on `wr_en` loads `wr_data` at that edge, overriding any increment. The first two Q4 edges after the write then produce no increment. While `cfg_assign_wdt`=0, the write also zeroes the prescaler count.
- R4: With `cfg_src_ext`=0 and `cfg_assign_wdt`=0, ratio value n makes the timer advance once every 2^(n+1) Q4 edges. Counting starts from a cleared prescaler, so the j-th Q4 edge after a write advances the timer when j is a multiple of 2^(n+1).
- R5: An increment from 0xFF gives 0x00, and `tmr_ovf` is high for exactly that one cycle. A write never raises `tmr_ovf`.
- R6: With `cfg_src_ext`=1 and no prescaler, the timer counts one per selected pin edge. A value of 0 on `cfg_edge_fall` selects the rising edge and 1 selects the falling edge. Every edge is counted when the pin stays at least two clocks high and at least two clocks low.
- R7: With `cfg_src_ext`=1 and `cfg_assign_wdt`=0, the prescaler counts selected pin edges, and bit n of its count feeds the sampler. The timer advances at selected edges number 2^n, 2^n+2^(n+1), 2^n+2·2^(n+1), and so on after the prescaler clear.
- R8: With the external source and no prescaler, a pin change made between two clock edges shows on `tmr_value` after the 4th to the 7th following clock edge. This equals 3 to 7 oscillator periods.
- R9: `wdt_tick` is a one-cycle pulse, one clock after a `wdt_src` strobe. With `cfg_assign_wdt`=1, only every 2^n-th strobe after a clear gives a tick, where n is the ratio. With `cfg_assign_wdt`=0, every strobe gives a tick.
- R10: `wdt_clr` zeroes the prescaler only while `cfg_assign_wdt`=1. While the prescaler belongs to the timer, `wdt_clr` has no effect on the timer's division.
- R11: While `cfg_assign_wdt`=1, a timer write does not disturb the watchdog division.
- R12: Timer changes that do not come from a write happen only on the Q4 edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one phase per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | External count input |
| cfg_src_ext | input | 1 | 1: count the pin, 0: count instruction cycles |
| cfg_edge_fall | input | 1 | 1: falling pin edge, 0: rising pin edge |
| cfg_assign_wdt | input | 1 | 1: prescaler on the watchdog path, 0: on the timer |
| cfg_ratio | input | 3 | Division ratio select n |
| wr_en | input | 1 | Timer write strobe |
| wr_data | input | 8 | Value loaded on a write |
| wdt_src | input | 1 | Tick strobe from the watchdog oscillator |
| wdt_clr | input | 1 | Watchdog clear strobe |
| tmr_value | output | 8 | Current timer value |
| tmr_ovf | output | 1 | One-cycle wrap pulse |
| wdt_tick | output | 1 | Divided watchdog tick pulse |

## Verification
Internal-source results are due on Q4 edges. After each write, the bench waits a whole multiple of four clocks, so exactly M Q4 edges have passed whatever the phase of the write. It compares the timer against a count of the Q4 indices j from 3 to M that meet the ratio. External counts arrive up to seven edges after a pin change, so the bench holds the pin still for at least twelve clocks before reading the timer. The latency check polls at every falling clock edge and records the edge on which the value moves. Watchdog ticks and overflow pulses are one clock wide, so the bench counts them over a window rather than at a fixed cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_t;

  localparam int unsigned WRITE_HOLDOFF = 2;
endpackage

// File: rtl/tmr_phase.sv
module tmr_phase
  import tmr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_t ph
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= PH_Q1;
    else        ph <= phase_t'(ph + 2'd1);
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int CW = 8,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [SW-1:0] sel,
  output logic          tmr_carry,
  output logic          wdt_carry,
  output logic          sel_bit
);
  logic [CW-1:0] cnt;
  logic [CW:0]   one_w;
  logic [SW:0]   tmr_sh;
  logic [CW:0]   tmr_mask_w;
  logic [CW:0]   wdt_mask_w;
  logic [CW-1:0] tmr_mask;
  logic [CW-1:0] wdt_mask;

  assign one_w      = {{CW{1'b0}}, 1'b1};
  assign tmr_sh     = {1'b0, sel} + 1'b1;
  assign tmr_mask_w = (one_w << tmr_sh) - one_w;
  assign wdt_mask_w = (one_w << sel) - one_w;
  assign tmr_mask   = tmr_mask_w[CW-1:0];
  assign wdt_mask   = wdt_mask_w[CW-1:0];

  // carry out of the selected stage, taken on the incrementing cycle
  assign tmr_carry = inc && ((cnt & tmr_mask) == tmr_mask);
  assign wdt_carry = inc && ((cnt & wdt_mask) == wdt_mask);
  assign sel_bit   = cnt[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tmr_sampler.sv
module tmr_sampler
  import tmr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_t ph,
  input  logic   pin_pol,
  input  logic   use_presc,
  input  logic   presc_bit,
  output logic   pin_rise,
  output logic   ext_tick
);
  logic pin_q, pin_q2;
  logic smp_a, smp_a_old, smp_b;
  logic src;

  assign pin_rise = pin_q & ~pin_q2;
  assign src      = use_presc ? presc_bit : pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= 1'b0;
      pin_q2 <= 1'b0;
    end else begin
      pin_q  <= pin_pol;
      pin_q2 <= pin_q;
    end
  end

  // samples taken at the end of Q2 and Q4; history keeps sequence
  // older-Q2, last-Q4, this-Q2 so each transition is examined once
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_a     <= 1'b0;
      smp_a_old <= 1'b0;
      smp_b     <= 1'b0;
    end else if (ph == PH_Q2) begin
      smp_a <= src;
    end else if (ph == PH_Q4) begin
      smp_a_old <= smp_a;
      smp_b     <= src;
    end
  end

  assign ext_tick = (ph == PH_Q4) &&
                    ((~smp_a_old & smp_b) | (~smp_b & smp_a));
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int TW = 8,
  parameter int PW = 8,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_pin,
  input  logic          cfg_src_ext,
  input  logic          cfg_edge_fall,
  input  logic          cfg_assign_wdt,
  input  logic [RW-1:0] cfg_ratio,
  input  logic          wr_en,
  input  logic [TW-1:0] wr_data,
  input  logic          wdt_src,
  input  logic          wdt_clr,
  output logic [TW-1:0] tmr_value,
  output logic          tmr_ovf,
  output logic          wdt_tick
);
  localparam int HW = $clog2(WRITE_HOLDOFF + 1);

  phase_t        ph;
  logic          tick_q4;
  logic          pin_pol;
  logic          pin_rise, ext_tick;
  logic          p_tcarry, p_wcarry, p_bit;
  logic          presc_inc, presc_clr;
  logic          inc_req, do_inc;
  logic [HW-1:0] holdoff;

  tmr_phase u_phase (.clk(clk), .rst_n(rst_n), .ph(ph));

  assign tick_q4 = (ph == PH_Q4);
  assign pin_pol = ext_pin ^ cfg_edge_fall;

  assign presc_inc = cfg_assign_wdt ? wdt_src : (cfg_src_ext ? pin_rise : tick_q4);
  assign presc_clr = cfg_assign_wdt ? wdt_clr : wr_en;

  tmr_prescaler #(.CW(PW), .SW(RW)) u_presc (
    .clk(clk), .rst_n(rst_n), .clr(presc_clr), .inc(presc_inc),
    .sel(cfg_ratio), .tmr_carry(p_tcarry), .wdt_carry(p_wcarry),
    .sel_bit(p_bit)
  );

  tmr_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .ph(ph), .pin_pol(pin_pol),
    .use_presc(~cfg_assign_wdt), .presc_bit(p_bit),
    .pin_rise(pin_rise), .ext_tick(ext_tick)
  );

  assign inc_req = cfg_src_ext ? ext_tick : (cfg_assign_wdt ? tick_q4 : p_tcarry);
  assign do_inc  = inc_req && (holdoff == '0) && !wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         holdoff <= '0;
    else if (wr_en)                     holdoff <= HW'(WRITE_HOLDOFF);
    else if (tick_q4 && holdoff != '0)  holdoff <= holdoff - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_value <= '0;
      tmr_ovf   <= 1'b0;
    end else begin
      tmr_ovf <= do_inc && (tmr_value == '1);
      if (wr_en)       tmr_value <= wr_data;
      else if (do_inc) tmr_value <= tmr_value + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdt_tick <= 1'b0;
    else        wdt_tick <= cfg_assign_wdt ? p_wcarry : wdt_src;
  end
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk
  import tmr_pkg::*;
#(
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [TW-1:0] wr_data,
  input logic [TW-1:0] tmr_value,
  input logic          tmr_ovf,
  input logic          wdt_tick,
  input logic          wdt_src,
  input phase_t        ph
);
  a_r3_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> tmr_value == $past(wr_data));

  a_r3_holdoff_next: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en, 2) && !$past(wr_en)) |-> tmr_value == $past(tmr_value));

  a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && tmr_value != $past(tmr_value)) |->
      tmr_value == TW'($past(tmr_value) + 1'b1));

  a_r12_change_on_q4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && tmr_value != $past(tmr_value)) |-> $past(ph) == PH_Q4);

  a_r5_ovf_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |-> tmr_value == '0);

  a_r5_ovf_single: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> !tmr_ovf);

  a_r9_tick_from_src: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_tick |-> $past(wdt_src));
endmodule

bind tmr_unit tmr_unit_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .tmr_value(tmr_value), .tmr_ovf(tmr_ovf), .wdt_tick(wdt_tick),
  .wdt_src(wdt_src), .ph(ph)
);

// File: tb/tmr_unit_tb.sv
module tmr_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_pin = 1'b0;
  logic       cfg_src_ext = 1'b0;
  logic       cfg_edge_fall = 1'b0;
  logic       cfg_assign_wdt = 1'b1;
  logic [2:0] cfg_ratio = 3'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wdt_src = 1'b0;
  logic       wdt_clr = 1'b0;
  logic [7:0] tmr_value;
  logic       tmr_ovf;
  logic       wdt_tick;

  int n_run = 0;
  int n_fail = 0;
  int ovf_seen = 0;
  int tick_seen = 0;

  always #10 clk = ~clk;

  tmr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .cfg_src_ext(cfg_src_ext),
    .cfg_edge_fall(cfg_edge_fall), .cfg_assign_wdt(cfg_assign_wdt),
    .cfg_ratio(cfg_ratio), .wr_en(wr_en), .wr_data(wr_data),
    .wdt_src(wdt_src), .wdt_clr(wdt_clr), .tmr_value(tmr_value),
    .tmr_ovf(tmr_ovf), .wdt_tick(wdt_tick)
  );

  always @(negedge clk) begin
    if (rst_n && tmr_ovf)  ovf_seen++;
    if (rst_n && wdt_tick) tick_seen++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Q4 edges j = 1..m after a write; j = 1,2 held off; advance when j % d == 0
  function automatic int exp_int(input int m, input int d);
    int c = 0;
    for (int j = 3; j <= m; j++) if (j % d == 0) c++;
    return c;
  endfunction

  // selected edges k = 1..p; prescaler bit n rises at k = 2^n mod 2^(n+1)
  function automatic int exp_ext_presc(input int p, input int n);
    int c = 0;
    for (int k = 1; k <= p; k++) if (k % (2 << n) == (1 << n)) c++;
    return c;
  endfunction

  task automatic ext_pulses(input int p, input int hi, input int lo);
    for (int i = 0; i < p; i++) begin
      ext_pin = 1'b1; step(hi);
      ext_pin = 1'b0; step(lo);
    end
  endtask

  task automatic wdt_pulses(input int p);
    for (int i = 0; i < p; i++) begin
      wdt_src = 1'b1; step(1);
      wdt_src = 1'b0; step(1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int base, m, n, p, hi, lo, lat, t0;
    void'($urandom(32'd20240611));
    step(3);
    // R1 reset state
    chk("R1 timer", int'(tmr_value), 0);
    chk("R1 ovf", int'(tmr_ovf), 0);
    chk("R1 tick", int'(wdt_tick), 0);
    rst_n = 1'b1;
    step(2);

    // R2 internal, no prescaler
    do_write(8'h10); step(4 * 20);
    chk("R2 internal count", int'(tmr_value), 16 + exp_int(20, 1));

    // R3 write holdoff: only 2 Q4 edges after write -> no change
    do_write(8'h33); step(8);
    chk("R3 holdoff", int'(tmr_value), 8'h33);

    // R5 wrap and overflow pulse
    ovf_seen = 0;
    do_write(8'hFE); step(4 * 4);
    chk("R5 wrap value", int'(tmr_value), 0);
    chk("R5 ovf pulses", ovf_seen, 1);
    ovf_seen = 0;
    do_write(8'hFF); step(4);
    chk("R5 write gives no ovf", ovf_seen, 0);

    // R4 internal with prescaler, directed ratios and R3 prescaler clear
    cfg_assign_wdt = 1'b0;
    for (int r = 0; r < 3; r++) begin
      cfg_ratio = 3'(r);
      do_write(8'h00); step(4 * 37);
      chk("R4 ratio", int'(tmr_value), exp_int(37, 2 << r));
    end

    // R10 wdt_clr ignored while timer owns the prescaler
    cfg_ratio = 3'd1; wdt_clr = 1'b1;
    do_write(8'h00); step(4 * 20);
    wdt_clr = 1'b0;
    chk("R10 clr ignored on timer", int'(tmr_value), exp_int(20, 4));

    // random internal runs (R2/R4)
    for (int i = 0; i < 8; i++) begin
      cfg_assign_wdt = 1'($urandom % 2);
      n = $urandom % 5; m = 10 + ($urandom % 70);
      cfg_ratio = 3'(n);
      do_write(8'h00); step(4 * m);
      chk(cfg_assign_wdt ? "R2 random" : "R4 random", int'(tmr_value),
          exp_int(m, cfg_assign_wdt ? 1 : (2 << n)));
    end

    // R6 external, no prescaler, both polarities, min pulse 2/2
    cfg_assign_wdt = 1'b1; cfg_src_ext = 1'b1;
    for (int pol = 0; pol < 2; pol++) begin
      cfg_edge_fall = 1'(pol); ext_pin = 1'b0; step(12);
      do_write(8'h00); step(12);
      ext_pulses(9, 2, 2); step(12);
      chk("R6 ext edges 2/2", int'(tmr_value), 9);
    end
    for (int i = 0; i < 6; i++) begin
      cfg_edge_fall = 1'($urandom % 2); ext_pin = 1'b0; step(12);
      do_write(8'h00); step(12);
      p = 5 + ($urandom % 16);
      for (int k = 0; k < p; k++) begin
        hi = 2 + ($urandom % 5); lo = 2 + ($urandom % 5);
        ext_pulses(1, hi, lo);
      end
      step(12);
      chk("R6 ext random", int'(tmr_value), p);
    end

    // R8 latency, four phase offsets
    cfg_edge_fall = 1'b0; ext_pin = 1'b0; step(12);
    do_write(8'h00); step(12);
    for (int d = 0; d < 4; d++) begin
      step(d);
      t0 = int'(tmr_value);
      ext_pin = 1'b1; lat = 0;
      for (int k = 1; k <= 10; k++) begin
        step(1);
        if (lat == 0 && int'(tmr_value) != t0) lat = k;
      end
      chk("R8 latency in 4..7 edges", int'(lat >= 4 && lat <= 7), 1);
      ext_pin = 1'b0; step(10);
    end

    // R7 external with prescaler
    cfg_assign_wdt = 1'b0;
    for (int i = 0; i < 4; i++) begin
      n = (i < 2) ? i : ($urandom % 4);
      p = 6 + ($urandom % 20);
      cfg_ratio = 3'(n); ext_pin = 1'b0; step(12);
      do_write(8'h00); step(12);
      ext_pulses(p, 4, 4); step(30);
      chk("R7 ext prescaled", int'(tmr_value), exp_ext_presc(p, n));
    end
    cfg_src_ext = 1'b0;

    // R9 watchdog tick: timer-owned -> undivided
    tick_seen = 0;
    wdt_pulses(7); step(3);
    chk("R9 undivided tick", tick_seen, 7);

    // R9 watchdog-owned ratios
    cfg_assign_wdt = 1'b1;
    for (int r = 0; r < 4; r++) begin
      cfg_ratio = 3'(r);
      wdt_clr = 1'b1; step(1); wdt_clr = 1'b0;
      tick_seen = 0; p = 5 + ($urandom % 20);
      wdt_pulses(p); step(3);
      chk("R9 divided tick", tick_seen, p / (1 << r));
    end

    // R10 wdt_clr clears while watchdog owns prescaler
    cfg_ratio = 3'd2;
    wdt_clr = 1'b1; step(1); wdt_clr = 1'b0;
    tick_seen = 0;
    wdt_pulses(3);
    wdt_clr = 1'b1; step(1); wdt_clr = 1'b0;
    wdt_pulses(3); step(3);
    chk("R10 clr restarts division", tick_seen, 0);

    // R11 timer write leaves watchdog division alone
    wdt_clr = 1'b1; step(1); wdt_clr = 1'b0;
    tick_seen = 0;
    wdt_pulses(3);
    do_write(8'h5A);
    wdt_pulses(1); step(3);
    chk("R11 write keeps wdt count", tick_seen, 1);

    base = 0;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail + base);
    $finish;
  end
endmodule